// File: doc/BRIEF.md
# Event Status and Interrupt Unit

This unit sits between a small network controller's datapath and its host register port. The datapath raises one-cycle pulses for five kinds of event: a received frame completed, a transmitted frame completed, a receive overflow, a transmit underrun and a change of link state. Each pulse is held in a sticky status register until the host clears it by writing a one to the bit. A mask register chooses which of the low four status bits may raise the single interrupt line. The interrupt line is registered.

Every receive-overflow pulse also advances a 7-bit statistic counter. The counter is controlled by a two-state machine. In state `CNT_RUN` it counts. The transition `RUN_TO_SAT` happens on the overflow pulse that arrives while the count is 127. That transition sets a sticky flag in the counter register and raises its own maskable status bit. In state `CNT_SAT` the count holds at 127. The transition `SAT_TO_RUN` (and also `RUN_CLEAR` from `CNT_RUN`) happens when the host reads the counter register. The read clears both the count and the flag. The two top bits of the status register are fixed by a parameter and report the width of the host bus.

The host reaches the unit through a synchronous byte port. A 2-bit register select chooses the register, together with a write strobe and a read strobe. Read data is combinational from the selected register.

Top module: `evt_irq_unit`

## Requirements
- R1: After reset, status bits 5:0 read 0, the mask reads 0x00, the counter register reads 0x00 and `irq` is 0.
- R2: A pulse on `ev_rx_done`, `ev_tx_done`, `ev_rx_ovf`, `ev_tx_under` or `ev_link_chg` sets status bit 0, 1, 2, 4 or 5 respectively at the next clock edge. The status register is at select 0. The bit then stays set with no further pulses.
- R3: A write to select 0 clears each of status bits 5:0 whose write-data bit is 1. Bits written as 0 are unchanged.
- R4: When an event pulse arrives in the same cycle as a write-one-to-clear of its own status bit, the bit remains set.
- R5: Status bits 7:6 always read the `BUS_MODE` parameter, and writes do not change them. The encoding is 10b for an 8-bit bus, 00b for a 16-bit bus and 01b for a 32-bit bus; the default is 10b.
- R6: The mask register is at select 1. Writes store write-data bits 3:0, and bits 7:4 read as 0.
- R7: `irq` equals the OR over bits 3:0 of (status AND mask), delayed by one clock. Status bits 4 and 5 never raise `irq`.
- R8: The counter register is at select 2. Bits 6:0 hold the number of `ev_rx_ovf` pulses since the last clear, and bit 7 is the overflow flag.
- R9: An `ev_rx_ovf` pulse while the count is 127 and the flag is clear does three things: it sets the flag, it keeps the count at 127, and it sets status bit 3. Later pulses leave the counter register unchanged.
- R10: While `reg_rd` is high with select 2, the read data shows the value before the clear. The clock edge then clears the count and the flag. An `ev_rx_ovf` pulse in that same cycle leaves the count at 1.
- R11: Select 3 reads 0x00. Writes to select 2 or select 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rx_done | input | 1 | Receive-complete event pulse |
| ev_tx_done | input | 1 | Transmit-complete event pulse |
| ev_rx_ovf | input | 1 | Receive-overflow event pulse |
| ev_tx_under | input | 1 | Transmit-underrun event pulse |
| ev_link_chg | input | 1 | Link-change event pulse |
| reg_addr | input | 2 | Register select: 0 status, 1 mask, 2 counter, 3 unused |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (only affects the counter register) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Registered interrupt request |

## Verification
Two pairs of operations can land in the same cycle. The first pair is an event pulse and a host write-one-to-clear of that same status bit. The second pair is a receive-overflow pulse and a read of the counter, including the case where the counter is at 127. Directed steps drive each pair of operations in one cycle, and random stimulus keeps producing both pairs. After every cycle a bench model built from the requirements predicts all registers and `irq`, and the bench compares the design against it: a set must win over a clear, and a read-clear must be followed by a count of exactly 1.

// File: rtl/evtirq_pkg.sv
package evtirq_pkg;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_OVFCNT = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        CNT_RUN = 1'b0,
        CNT_SAT = 1'b1
    } cnt_state_e;

    localparam int N_STAT    = 6;
    localparam int N_MASKED  = 4;
    localparam int B_RXDONE  = 0;
    localparam int B_TXDONE  = 1;
    localparam int B_RXOVF   = 2;
    localparam int B_CNTWRAP = 3;
    localparam int B_TXUNDER = 4;
    localparam int B_LINK    = 5;

endpackage

// File: rtl/evt_status_bits.sv
module evt_status_bits #(
    parameter int N_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_BITS-1:0] set_i,
    input  logic [N_BITS-1:0] clr_i,
    output logic [N_BITS-1:0] stat_o
);

    for (genvar g = 0; g < N_BITS; g++) begin : g_bit
        logic bit_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else begin
                // a set in the same cycle overrides the clear
                bit_q <= set_i[g] | (bit_q & ~clr_i[g]);
            end
        end

        assign stat_o[g] = bit_q;

        AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> stat_o[g]); // R4
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !stat_o[g]); // R3
        AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_o[g] && !clr_i[g]) |=> stat_o[g]); // R2
    end

endmodule

// File: rtl/evt_ovf_counter.sv
module evt_ovf_counter
    import evtirq_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             rd_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             sat_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             wrap_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_RUN;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        wrap_d  = 1'b0;
        if (rd_clr_i) begin
            // RUN_CLEAR / SAT_TO_RUN; a coincident event counts after the clear
            state_d = CNT_RUN;
            count_d = inc_i ? CNT_ONE : '0;
        end else begin
            unique case (state_q)
                CNT_RUN: begin
                    if (inc_i) begin
                        if (count_q == CNT_MAX) begin
                            state_d = CNT_SAT;   // RUN_TO_SAT
                            wrap_d  = 1'b1;
                        end else begin
                            count_d = count_q + CNT_ONE;
                        end
                    end
                end
                CNT_SAT: begin
                    state_d = CNT_SAT;
                end
                default: begin
                    state_d = CNT_RUN;
                end
            endcase
        end
    end

    assign count_o = count_q;
    assign sat_o   = (state_q == CNT_SAT);
    assign wrap_o  = wrap_d;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_RUN && inc_i && !rd_clr_i && count_q != CNT_MAX)
        |=> (count_q == $past(count_q) + CNT_ONE)); // R8
    AST_SAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_SAT && !rd_clr_i) |=> (sat_o && count_q == CNT_MAX)); // R9
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && !inc_i) |=> (!sat_o && count_q == '0)); // R10
    AST_READ_AND_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && inc_i) |=> (!sat_o && count_q == CNT_ONE)); // R10

endmodule

// File: rtl/evt_irq_gate.sv
module evt_irq_gate #(
    parameter int MSK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [MSK_W-1:0] wdata_i,
    input  logic [MSK_W-1:0] stat_i,
    output logic [MSK_W-1:0] mask_o,
    output logic             irq_o
);

    logic [MSK_W-1:0] mask_q;
    logic             irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_i) begin
            mask_q <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(stat_i & mask_q);
        end
    end

    assign mask_o = mask_q;
    assign irq_o  = irq_q;

    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (mask_o == $past(wdata_i))); // R6
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_o)); // R6

endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
    import evtirq_pkg::*;
#(
    parameter logic [1:0] BUS_MODE = 2'b10,
    parameter int         DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_rx_done,
    input  logic              ev_tx_done,
    input  logic              ev_rx_ovf,
    input  logic              ev_tx_under,
    input  logic              ev_link_chg,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    localparam int CNT_W = DATA_W - 1;

    reg_sel_e            sel;
    logic [N_STAT-1:0]   stat_set, stat_clr, stat;
    logic [N_MASKED-1:0] mask;
    logic [CNT_W-1:0]    ovf_count;
    logic                ovf_sat, ovf_wrap;
    logic                wr_stat, wr_mask, rd_cnt;
    logic                wdata_unused;

    assign sel     = reg_sel_e'(reg_addr);
    assign wr_stat = reg_wr && (sel == SEL_STATUS);
    assign wr_mask = reg_wr && (sel == SEL_MASK);
    assign rd_cnt  = reg_rd && (sel == SEL_OVFCNT);

    assign wdata_unused = ^reg_wdata[DATA_W-1:N_STAT];

    always_comb begin
        stat_set            = '0;
        stat_set[B_RXDONE]  = ev_rx_done;
        stat_set[B_TXDONE]  = ev_tx_done;
        stat_set[B_RXOVF]   = ev_rx_ovf;
        stat_set[B_CNTWRAP] = ovf_wrap;
        stat_set[B_TXUNDER] = ev_tx_under;
        stat_set[B_LINK]    = ev_link_chg;
        stat_clr            = wr_stat ? reg_wdata[N_STAT-1:0] : '0;
    end

    evt_status_bits #(.N_BITS(N_STAT)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (stat_set),
        .clr_i  (stat_clr),
        .stat_o (stat)
    );

    evt_ovf_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (ev_rx_ovf),
        .rd_clr_i (rd_cnt),
        .count_o  (ovf_count),
        .sat_o    (ovf_sat),
        .wrap_o   (ovf_wrap)
    );

    evt_irq_gate #(.MSK_W(N_MASKED)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_mask),
        .wdata_i (reg_wdata[N_MASKED-1:0]),
        .stat_i  (stat[N_MASKED-1:0]),
        .mask_o  (mask),
        .irq_o   (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_STATUS: reg_rdata = {BUS_MODE, stat};
            SEL_MASK:   reg_rdata = {{(DATA_W-N_MASKED){1'b0}}, mask};
            SEL_OVFCNT: reg_rdata = {ovf_sat, ovf_count};
            default:    reg_rdata = '0;
        endcase
    end

    AST_WRAP_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_sat) |-> stat[B_CNTWRAP]); // R9
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[B_RXDONE] && mask[B_RXDONE]) |=> irq); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> !irq); // R7
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_SPARE) |-> (reg_rdata == '0)); // R11

endmodule

// File: tb/test_evt_irq_unit.sv
module test_evt_irq_unit;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ev_rx_done, ev_tx_done, ev_rx_ovf, ev_tx_under, ev_link_chg;
    logic [1:0] reg_addr;
    logic       reg_wr, reg_rd;
    logic [7:0] reg_wdata, reg_rdata;
    logic       irq;

    always #5 clk = ~clk;

    evt_irq_unit i_evt_irq_unit (
        .clk(clk), .rst_n(rst_n),
        .ev_rx_done(ev_rx_done), .ev_tx_done(ev_tx_done), .ev_rx_ovf(ev_rx_ovf),
        .ev_tx_under(ev_tx_under), .ev_link_chg(ev_link_chg),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [5:0] m_stat;
    logic [3:0] m_mask;
    logic [6:0] m_cnt;
    logic       m_flag;
    logic       m_irq;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] f_view(input logic [1:0] a);
        case (a)
            2'd0:    return {2'b10, m_stat};
            2'd1:    return {4'h0, m_mask};
            2'd2:    return {m_flag, m_cnt};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic f_wrap(input logic ovf_ev, input logic rdc);
        return ovf_ev && !rdc && !m_flag && (m_cnt == 7'h7F);
    endfunction

    task automatic idle_inputs();
        {ev_link_chg, ev_tx_under, ev_rx_ovf, ev_tx_done, ev_rx_done} = 5'b0;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    endtask

    // ev bit order: 0 rx_done, 1 tx_done, 2 rx_ovf, 3 tx_under, 4 link_chg
    task automatic step(input logic [4:0] ev, input logic wr, input logic rd,
                        input logic [1:0] a, input logic [7:0] wd, input string tag);
        logic       rdc, wr_s, wrp;
        logic [5:0] n_stat;
        logic [3:0] n_mask;
        logic [6:0] n_cnt;
        logic       n_flag, n_irq;
        @(negedge clk);
        {ev_link_chg, ev_tx_under, ev_rx_ovf, ev_tx_done, ev_rx_done} = ev;
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        #1;
        chk(tag, reg_rdata, f_view(a));
        rdc    = rd && (a == 2'd2);
        wr_s   = wr && (a == 2'd0);
        wrp    = f_wrap(ev[2], rdc);
        n_stat = (m_stat & ~(wr_s ? wd[5:0] : 6'h00)) | {ev[4], ev[3], wrp, ev[2], ev[1], ev[0]};
        n_mask = (wr && a == 2'd1) ? wd[3:0] : m_mask;
        n_irq  = |(m_stat[3:0] & m_mask);
        n_cnt  = m_cnt; n_flag = m_flag;
        if (rdc) begin
            n_cnt = ev[2] ? 7'd1 : 7'd0; n_flag = 1'b0;
        end else if (ev[2] && !m_flag) begin
            if (m_cnt == 7'h7F) n_flag = 1'b1;
            else n_cnt = m_cnt + 7'd1;
        end
        @(posedge clk);
        #1;
        m_stat = n_stat; m_mask = n_mask; m_cnt = n_cnt; m_flag = n_flag; m_irq = n_irq;
        idle_inputs();
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R7 irq"}, {7'h0, irq}, {7'h0, m_irq});
        reg_addr = 2'd0; #1; chk({tag, " R3 status"}, reg_rdata, f_view(2'd0));
        reg_addr = 2'd1; #1; chk({tag, " R6 mask"}, reg_rdata, f_view(2'd1));
        reg_addr = 2'd2; #1; chk({tag, " R8 counter"}, reg_rdata, f_view(2'd2));
        reg_addr = 2'd0;
    endtask

    task automatic read_now(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a; #1;
        chk(tag, reg_rdata, exp);
        reg_addr = 2'd0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        m_stat = '0; m_mask = '0; m_cnt = '0; m_flag = 1'b0; m_irq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1, R5: reset values
        chk("R1 irq after reset", {7'h0, irq}, 8'h00);
        read_now(2'd0, 8'h80, "R1 R5 status after reset");
        read_now(2'd1, 8'h00, "R1 mask after reset");
        read_now(2'd2, 8'h00, "R1 counter after reset");

        // R2: each event sets its own bit
        step(5'b00001, 0, 0, 0, 8'h00, "R2 rx_done");
        read_now(2'd0, 8'h81, "R2 rx_done sets bit0");
        step(5'b00010, 0, 0, 0, 8'h00, "R2 tx_done");
        step(5'b01000, 0, 0, 0, 8'h00, "R2 tx_under");
        step(5'b10000, 0, 0, 0, 8'h00, "R2 link_chg");
        read_now(2'd0, 8'hB3, "R2 bits 0 1 4 5 set");
        step(5'b00100, 0, 0, 0, 8'h00, "R2 rx_ovf");
        read_now(2'd0, 8'hB7, "R2 bit2 set");
        read_now(2'd2, 8'h01, "R8 one overflow counted");

        // R3, R5: clear by write-one, mode bits fixed
        step(5'b0, 1, 0, 0, 8'h05, "R3 clear 0 and 2");
        read_now(2'd0, 8'hB2, "R3 bits 0 2 cleared others kept");
        step(5'b0, 1, 0, 0, 8'hC0, "R5 write mode bits");
        read_now(2'd0, 8'hB2, "R5 mode bits unchanged");
        step(5'b0, 1, 0, 0, 8'h3F, "R3 clear all");
        read_now(2'd0, 8'h80, "R3 all cleared");

        // R4: set beats clear
        step(5'b00001, 1, 0, 0, 8'h01, "R4 set and clear together");
        read_now(2'd0, 8'h81, "R4 bit0 stays set");

        // R6, R7: mask and irq timing
        step(5'b0, 1, 0, 1, 8'hFF, "R6 mask write");
        read_now(2'd1, 8'h0F, "R6 mask upper bits zero");
        chk("R7 irq not yet", {7'h0, irq}, 8'h00);
        step(5'b0, 0, 0, 0, 8'h00, "R7 wait");
        chk("R7 irq after one cycle", {7'h0, irq}, 8'h01);
        step(5'b0, 1, 0, 0, 8'h01, "R7 clear bit0");
        step(5'b0, 0, 0, 0, 8'h00, "R7 wait");
        chk("R7 irq drops", {7'h0, irq}, 8'h00);
        step(5'b11000, 0, 0, 0, 8'h00, "R7 bits 4 5 only");
        step(5'b0, 0, 0, 0, 8'h00, "R7 wait");
        step(5'b0, 0, 0, 0, 8'h00, "R7 wait");
        chk("R7 bits 4 5 raise no irq", {7'h0, irq}, 8'h00);

        // R8, R9: counter to saturation (already 1)
        for (int i = 0; i < 126; i++) step(5'b00100, 0, 0, 0, 8'h00, "R8 count");
        read_now(2'd2, 8'h7F, "R8 count 127 no flag");
        read_now(2'd0, 8'hB4, "R9 no wrap bit yet");
        step(5'b00100, 0, 0, 0, 8'h00, "R9 wrap");
        read_now(2'd2, 8'hFF, "R9 flag set count held");
        read_now(2'd0, 8'hBC, "R9 wrap status bit3");
        step(5'b00100, 0, 0, 0, 8'h00, "R9 after saturate");
        read_now(2'd2, 8'hFF, "R9 saturated unchanged");

        // R11: writes to counter and spare ignored, spare reads zero
        step(5'b0, 1, 0, 2, 8'h00, "R11 write counter");
        step(5'b0, 1, 0, 3, 8'hFF, "R11 write spare");
        read_now(2'd2, 8'hFF, "R11 counter unchanged");
        read_now(2'd3, 8'h00, "R11 spare reads zero");
        read_now(2'd0, 8'hBC, "R11 status unchanged");

        // R10: read shows old value then clears; read with concurrent event
        step(5'b00100, 0, 1, 2, 8'h00, "R10 read returns pre-clear value");
        read_now(2'd2, 8'h01, "R10 read plus event gives 1");
        step(5'b0, 0, 1, 2, 8'h00, "R10 plain read");
        read_now(2'd2, 8'h00, "R10 cleared");
        check_all("R10 directed end");

        // random phase
        void'($urandom(32'd4711));
        for (int i = 0; i < 1500; i++) begin
            logic [4:0] ev;
            logic       wr, rd;
            logic [1:0] a;
            ev[0] = ($urandom % 8) == 0;
            ev[1] = ($urandom % 8) == 0;
            ev[2] = ($urandom % 4) != 0;
            ev[3] = ($urandom % 10) == 0;
            ev[4] = ($urandom % 10) == 0;
            wr    = ($urandom % 5) == 0;
            rd    = ($urandom % 150) == 0;
            a     = rd ? 2'd2 : 2'($urandom % 4);
            step(ev, wr, rd, a, 8'($urandom), "R4 R10 random");
            check_all("random");
        end

        done = 1;
        finish_run();
    end

endmodule